// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer Core

This block is a 16-bit timer that counts up or down. It steps on ticks from an 8-bit prescaler. It has two general-purpose slot registers and a match register. The mode inputs set the role of each slot. A slot can be a reload source, a capture target or, for slot 1, a live copy of the count. The same inputs choose whether the counter runs free, stops after one period, or reloads alternately from the two slots.

A clear puts the counter back at its starting value: 0000h when counting up, FFFFh when counting down. A clear also restarts the prescaler. A clear can come from three sources: a software strobe, a capture into slot 0, or a match against the match register. The two automatic sources are each enabled by their own input. Software writes the registers through three write strobes that share one data bus. The counter value, the registers and two single-cycle event flags are available as outputs at all times.

Top module: `mtimer_core`

## Requirements
- R1: While reset is held, the counter, both slots, the match register and the prescaler are zero. With up counting selected, eoc_o stays low.
- R2: The prescaler loads psc_ld_i each time it reaches zero. The counter steps once every psc_ld_i+1 cycles, and the first step comes on the first clock edge after reset.
- R3: Free-running operation is selected when slot0_cap_i=1 and either dual_i=1 or cont_i=1. In this operation the counter wraps FFFFh->0000h (up) or 0000h->FFFFh (down) and eoc_o never rises.
- R4: Outside free-running operation, a tick with the counter at its end value (FFFFh up, 0000h down) raises eoc_o for that cycle. On the same edge the counter loads the selected reload slot instead of stepping.
- R5: With cont_i=0, the counter stops after an end-of-count reload. It holds its value and produces no further events until a clear.
- R6: Dual-load operation is selected by dual_i=1 and slot0_cap_i=0. Successive end-of-count reloads alternate between slot 0 and slot 1. While dual_i=0 the pointer is held at slot 0, so the first reload after dual_i rises always comes from slot 0.
- R7: When dual_i=0 and mon_dis_i=0, slot 1 follows the counter and equals cnt_o after every edge. Writes to slot 1 have no effect in this state.
- R8: When slot0_cap_i=1, cap_i copies the counter into slot 0. With dual_i=1 as well, successive captures go to slot 0, then slot 1, then slot 0 again, and so on. When slot0_cap_i=0, cap_i leaves slot 0 unchanged.
- R9: A pulse on sw_clr_i sets the counter to 0000h (down_i=0) or FFFFh (down_i=1) on the next edge. It also restarts the prescaler, so the next step comes psc_ld_i+1 cycles later.
- R10: With clr_cap_i=1, every capture into slot 0 stores the pre-clear count and clears the counter on the same edge.
- R11: hit_o pulses on a tick where the running counter equals the match register. With clr_cmp_i=1, that match clears the counter.
- R12: Any clear takes the place of the count step or reload on that edge. A clear also suppresses eoc_o in that cycle.
- R13: The write strobes load wr_data_i into slot 0, slot 1 and the match register. A capture or the slot-1 copy overrides a write to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Capture strobe |
| cont_i | input | 1 | 1: keep reloading; 0: stop after one period |
| down_i | input | 1 | 1: count down; 0: count up |
| dual_i | input | 1 | Enable dual-slot operation |
| slot0_cap_i | input | 1 | 1: slot 0 captures; 0: slot 0 is the reload source |
| mon_dis_i | input | 1 | 1: slot 1 does not follow the counter |
| clr_cap_i | input | 1 | Clear the counter on capture into slot 0 |
| clr_cmp_i | input | 1 | Clear the counter on a match |
| sw_clr_i | input | 1 | Software clear strobe |
| psc_ld_i | input | 8 | Prescaler reload value |
| wr_slot0_i | input | 1 | Write strobe for slot 0 |
| wr_slot1_i | input | 1 | Write strobe for slot 1 |
| wr_match_i | input | 1 | Write strobe for the match register |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| slot0_o | output | 16 | Slot 0 contents |
| slot1_o | output | 16 | Slot 1 contents |
| match_o | output | 16 | Match register contents |
| eoc_o | output | 1 | End-of-count pulse |
| hit_o | output | 1 | Match pulse |

## Verification
The bench targets the corner cases a faulty design would get wrong:
- **Slot pointer.** It drops dual_i for one cycle between dual-slot reloads. A pointer that is not forced back to slot 0 would reload from slot 1 at that point.
- **Clear at end of count.** It clears at the exact end value. A design that lets the count step or reload win would show a reload value or a stray eoc_o.
- **Free-run wrap and stopped state.** It wraps in free-running operation and waits in the stopped single-period state. A wrong mode decode would pulse eoc_o or keep counting.
- **Prescaler restart.** It checks that a clear restarts the prescaler, rather than letting the old phase carry on.
- **Capture order.** It checks capture alternation starting at slot 0.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef struct packed {
    logic free_run;   // wrap, no end of count
    logic dual_load;  // alternate reload slots
    logic dual_cap;   // alternate capture slots
    logic monitor;    // slot 1 follows counter
  } mode_t;

  function automatic mode_t mode_decode(input logic cont, input logic dual,
                                        input logic slot0_cap, input logic mon_dis);
    mode_t m;
    m.dual_load = dual & ~slot0_cap;
    m.dual_cap  = dual & slot0_cap;
    m.free_run  = slot0_cap & (dual | cont);
    m.monitor   = ~dual & ~mon_dis;
    return m;
  endfunction

endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] ld_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] psc_q;

  assign tick_o = (psc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   psc_q <= '0;
    else if (restart_i || tick_o)  psc_q <= ld_i;
    else                           psc_q <= psc_q - 1'b1;
  end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             down_i,
  input  logic             cont_i,
  input  logic             free_i,
  input  logic             dual_load_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] ld0_i,
  input  logic [CNT_W-1:0] ld1_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             eoc_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, ld_val;
  logic             halt_q, halt_d, sel_q;
  logic             run, at_end;

  assign run    = tick_i & ~halt_q;
  assign at_end = down_i ? (cnt_q == '0) : (cnt_q == CNT_TOP);
  assign hit_o  = run & (cnt_q == match_i);
  assign eoc_o  = run & ~clr_i & ~free_i & at_end;
  assign ld_val = (dual_load_i && sel_q) ? ld1_i : ld0_i;

  always_comb begin
    cnt_d  = cnt_q;
    halt_d = halt_q;
    if (clr_i) begin
      cnt_d  = down_i ? CNT_TOP : '0;
      halt_d = 1'b0;
    end else if (eoc_o) begin
      cnt_d  = ld_val;
      halt_d = ~cont_i;
    end else if (run) begin
      cnt_d  = down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  // reload pointer parks on slot 0 whenever dual mode is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     sel_q <= 1'b0;
    else if (!dual_i)                sel_q <= 1'b0;
    else if (eoc_o && dual_load_i)   sel_q <= ~sel_q;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

endmodule

// File: rtl/mtimer_regs.sv
module mtimer_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             cap_mode_i,
  input  logic             dual_cap_i,
  input  logic             monitor_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             wr_slot0_i,
  input  logic             wr_slot1_i,
  input  logic             wr_match_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] slot0_o,
  output logic [CNT_W-1:0] slot1_o,
  output logic [CNT_W-1:0] match_o,
  output logic             cap0_o
);

  localparam int NSLOT = 2;

  logic             csel_q, cap_en;
  logic [NSLOT-1:0] cap_to, wr_to;
  logic [CNT_W-1:0] slot_q [NSLOT];
  logic [CNT_W-1:0] match_q;

  assign cap_en    = cap_i & cap_mode_i;
  assign cap_to[0] = cap_en & ~(dual_cap_i & csel_q);
  assign cap_to[1] = cap_en & dual_cap_i & csel_q;
  assign wr_to     = {wr_slot1_i, wr_slot0_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          csel_q <= 1'b0;
    else if (!dual_cap_i) csel_q <= 1'b0;
    else if (cap_en)      csel_q <= ~csel_q;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic follow;
    if (s == 1) begin : g_mon
      assign follow = monitor_i;
    end else begin : g_nomon
      assign follow = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        slot_q[s] <= '0;
      else if (follow)    slot_q[s] <= cnt_nxt_i;
      else if (cap_to[s]) slot_q[s] <= cnt_i;
      else if (wr_to[s])  slot_q[s] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_q <= '0;
    else if (wr_match_i) match_q <= wr_data_i;
  end

  assign slot0_o = slot_q[0];
  assign slot1_o = slot_q[1];
  assign match_o = match_q;
  assign cap0_o  = cap_to[0];

endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             cont_i,
  input  logic             down_i,
  input  logic             dual_i,
  input  logic             slot0_cap_i,
  input  logic             mon_dis_i,
  input  logic             clr_cap_i,
  input  logic             clr_cmp_i,
  input  logic             sw_clr_i,
  input  logic [PSC_W-1:0] psc_ld_i,
  input  logic             wr_slot0_i,
  input  logic             wr_slot1_i,
  input  logic             wr_match_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] slot0_o,
  output logic [CNT_W-1:0] slot1_o,
  output logic [CNT_W-1:0] match_o,
  output logic             eoc_o,
  output logic             hit_o
);

  mode_t            mode;
  logic             tick, clr, hit, cap0;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign mode = mode_decode(cont_i, dual_i, slot0_cap_i, mon_dis_i);

  // software clear first, then capture, then match; all load the same value
  assign clr = sw_clr_i | (cap0 & clr_cap_i) | (hit & clr_cmp_i);

  mtimer_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (clr),
    .ld_i      (psc_ld_i),
    .tick_o    (tick)
  );

  mtimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .clr_i       (clr),
    .down_i      (down_i),
    .cont_i      (cont_i),
    .free_i      (mode.free_run),
    .dual_load_i (mode.dual_load),
    .dual_i      (dual_i),
    .ld0_i       (slot0_o),
    .ld1_i       (slot1_o),
    .match_i     (match_o),
    .cnt_o       (cnt),
    .cnt_nxt_o   (cnt_nxt),
    .eoc_o       (eoc_o),
    .hit_o       (hit)
  );

  mtimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_i),
    .cap_mode_i (slot0_cap_i),
    .dual_cap_i (mode.dual_cap),
    .monitor_i  (mode.monitor),
    .cnt_i      (cnt),
    .cnt_nxt_i  (cnt_nxt),
    .wr_slot0_i (wr_slot0_i),
    .wr_slot1_i (wr_slot1_i),
    .wr_match_i (wr_match_i),
    .wr_data_i  (wr_data_i),
    .slot0_o    (slot0_o),
    .slot1_o    (slot1_o),
    .match_o    (match_o),
    .cap0_o     (cap0)
  );

  assign cnt_o = cnt;
  assign hit_o = hit;

endmodule

// File: rtl/mtimer_core_chk.sv
module mtimer_core_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cap_i,
  input logic             cont_i,
  input logic             down_i,
  input logic             dual_i,
  input logic             slot0_cap_i,
  input logic             mon_dis_i,
  input logic             clr_cap_i,
  input logic             clr_cmp_i,
  input logic             sw_clr_i,
  input logic [PSC_W-1:0] psc_ld_i,
  input logic             wr_slot0_i,
  input logic             wr_slot1_i,
  input logic             wr_match_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] slot0_o,
  input logic [CNT_W-1:0] slot1_o,
  input logic [CNT_W-1:0] match_o,
  input logic             eoc_o,
  input logic             hit_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R9
  sw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && sw_clr_i |=> cnt_o == ($past(down_i) ? CNT_TOP : '0));

  // R3
  free_no_eoc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot0_cap_i && (dual_i || cont_i) |-> !eoc_o);

  // R7
  monitor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!mon_dis_i && !dual_i) |-> slot1_o == cnt_o);

  // R8
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && cap_i && slot0_cap_i && !dual_i |=> slot0_o == $past(cnt_o));

  // R8
  capture_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !slot0_cap_i && !wr_slot0_i |=> $stable(slot0_o));

  // R11
  match_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && hit_o && clr_cmp_i |=> cnt_o == ($past(down_i) ? CNT_TOP : '0));

endmodule

bind mtimer_core mtimer_core_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_i), .cont_i(cont_i), .down_i(down_i),
  .dual_i(dual_i), .slot0_cap_i(slot0_cap_i), .mon_dis_i(mon_dis_i),
  .clr_cap_i(clr_cap_i), .clr_cmp_i(clr_cmp_i), .sw_clr_i(sw_clr_i),
  .psc_ld_i(psc_ld_i), .wr_slot0_i(wr_slot0_i), .wr_slot1_i(wr_slot1_i),
  .wr_match_i(wr_match_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
  .slot0_o(slot0_o), .slot1_o(slot1_o), .match_o(match_o),
  .eoc_o(eoc_o), .hit_o(hit_o)
);

// File: tb/mtimer_core_bench.sv
`timescale 1ns/1ps
module mtimer_core_bench;

  localparam int W = 16;
  localparam int P = 8;
  localparam logic [W-1:0] TOP = '1;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         cap = 0, cont = 1, down = 0, dual = 0, s0cap = 0, mon_dis = 1;
  logic         clr_cap = 0, clr_cmp = 0, sw_clr = 0;
  logic [P-1:0] psc_ld = '0;
  logic         wr0 = 0, wr1 = 0, wrm = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt_o, slot0_o, slot1_o, match_o;
  logic         eoc_o, hit_o;

  always #4 clk = ~clk;

  mtimer_core u_mtimer_core (
    .clk_i(clk), .rst_ni(rst_ni), .cap_i(cap), .cont_i(cont), .down_i(down),
    .dual_i(dual), .slot0_cap_i(s0cap), .mon_dis_i(mon_dis), .clr_cap_i(clr_cap),
    .clr_cmp_i(clr_cmp), .sw_clr_i(sw_clr), .psc_ld_i(psc_ld), .wr_slot0_i(wr0),
    .wr_slot1_i(wr1), .wr_match_i(wrm), .wr_data_i(wdata), .cnt_o(cnt_o),
    .slot0_o(slot0_o), .slot1_o(slot1_o), .match_o(match_o), .eoc_o(eoc_o),
    .hit_o(hit_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_cnt, m_s0, m_s1, m_mt, n_cnt, n_s0, n_s1, n_mt;
  logic [P-1:0] m_psc, n_psc;
  logic         m_sel, m_csel, m_halt, n_sel, n_csel, n_halt;
  logic         e_eoc, e_hit;
  logic [W-1:0] v1, v2;

  task automatic chk16(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk1(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_s0 = '0; m_s1 = '0; m_mt = '0; m_psc = '0;
    m_sel = 0; m_csel = 0; m_halt = 0;
  endtask

  task automatic model_eval();
    logic fr, dl, dc, mon, tick, run, capen, c0, c1, clr, at_end;
    fr     = s0cap & (dual | cont);
    dl     = dual & ~s0cap;
    dc     = dual & s0cap;
    mon    = ~dual & ~mon_dis;
    tick   = (m_psc == '0);
    run    = tick & ~m_halt;
    e_hit  = run & (m_cnt == m_mt);
    capen  = cap & s0cap;
    c0     = capen & ~(dc & m_csel);
    c1     = capen & dc & m_csel;
    clr    = sw_clr | (c0 & clr_cap) | (e_hit & clr_cmp);
    at_end = down ? (m_cnt == '0) : (m_cnt == TOP);
    e_eoc  = run & ~clr & ~fr & at_end;
    n_psc  = (clr || tick) ? psc_ld : m_psc - 1'b1;
    n_cnt  = m_cnt; n_halt = m_halt;
    if (clr) begin n_cnt = down ? TOP : '0; n_halt = 0; end
    else if (e_eoc) begin n_cnt = (dl && m_sel) ? m_s1 : m_s0; n_halt = ~cont; end
    else if (run) n_cnt = down ? m_cnt - 1'b1 : m_cnt + 1'b1;
    n_sel  = !dual ? 1'b0 : (e_eoc && dl) ? ~m_sel : m_sel;
    n_csel = !dc ? 1'b0 : capen ? ~m_csel : m_csel;
    n_s0   = c0 ? m_cnt : wr0 ? wdata : m_s0;
    n_s1   = mon ? n_cnt : c1 ? m_cnt : wr1 ? wdata : m_s1;
    n_mt   = wrm ? wdata : m_mt;
  endtask

  // inputs are set at the falling edge; outputs compared 1 ns later
  task automatic cycle();
    #1;
    model_eval();
    chk16("R4", "cnt_o", cnt_o, m_cnt);
    chk16("R8", "slot0_o", slot0_o, m_s0);
    chk16("R7", "slot1_o", slot1_o, m_s1);
    chk16("R13", "match_o", match_o, m_mt);
    chk1("R4", "eoc_o", eoc_o, e_eoc);
    chk1("R11", "hit_o", hit_o, e_hit);
    @(posedge clk);
    m_cnt = n_cnt; m_s0 = n_s0; m_s1 = n_s1; m_mt = n_mt; m_psc = n_psc;
    m_sel = n_sel; m_csel = n_csel; m_halt = n_halt;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    #10;
    chk16("R1", "reset cnt", cnt_o, '0);
    chk16("R1", "reset slot0", slot0_o, '0);
    chk16("R1", "reset slot1", slot1_o, '0);
    chk16("R1", "reset match", match_o, '0);
    chk1("R1", "reset eoc", eoc_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 prescaler period 3, first step right after reset
    psc_ld = 8'd2;
    repeat (7) cycle();
    chk16("R2", "prescaled count", cnt_o, 16'd3);

    // R13 register writes
    psc_ld = 8'd0;
    wr0 = 1; wdata = 16'h1357; cycle(); wr0 = 0;
    wr1 = 1; wdata = 16'hA5A5; cycle(); wr1 = 0;
    wrm = 1; wdata = 16'h5A5A; cycle(); wrm = 0;
    chk16("R13", "slot0 write", slot0_o, 16'h1357);
    chk16("R13", "slot1 write", slot1_o, 16'hA5A5);
    chk16("R13", "match write", match_o, 16'h5A5A);

    // R7 monitor overrides a slot-1 write
    mon_dis = 0; wr1 = 1; wdata = 16'h1234; cycle(); wr1 = 0;
    chk16("R7", "slot1 follows", slot1_o, cnt_o);
    cycle();
    chk16("R7", "slot1 follows again", slot1_o, cnt_o);
    mon_dis = 1;

    // R9 clear restarts prescaler
    psc_ld = 8'd3; sw_clr = 1; cycle(); sw_clr = 0;
    chk16("R9", "clear up", cnt_o, 16'h0000);
    repeat (3) cycle();
    chk16("R9", "held by prescaler", cnt_o, 16'h0000);
    cycle();
    chk16("R9", "step after restart", cnt_o, 16'h0001);
    psc_ld = 8'd0; down = 1; sw_clr = 1; cycle(); sw_clr = 0;
    chk16("R9", "clear down", cnt_o, TOP);
    down = 0;

    // R11/R12 match clear
    clr_cmp = 1; sw_clr = 1; wrm = 1; wdata = 16'd3; cycle();
    sw_clr = 0; wrm = 0;
    repeat (3) cycle();
    #1 chk1("R11", "hit at match", hit_o, 1'b1);
    cycle();
    chk16("R12", "match clear beats step", cnt_o, 16'h0000);
    clr_cmp = 0;

    // R10 clear on capture
    s0cap = 1; cont = 0; clr_cap = 1;
    repeat (2) cycle();
    v1 = cnt_o; cap = 1; cycle(); cap = 0;
    chk16("R10", "captured pre-clear", slot0_o, v1);
    chk16("R10", "cleared by capture", cnt_o, 16'h0000);
    clr_cap = 0;

    // R8 dual capture order, then ignored capture
    cont = 1; dual = 1;
    repeat (2) cycle();
    v1 = cnt_o; cap = 1; cycle();
    v2 = cnt_o; cycle(); cap = 0;
    chk16("R8", "first capture to slot0", slot0_o, v1);
    chk16("R8", "second capture to slot1", slot1_o, v2);
    dual = 0; s0cap = 0; cap = 1; cycle(); cap = 0;
    chk16("R8", "capture ignored", slot0_o, v1);

    // R6 dual-load alternation
    dual = 1;
    wr0 = 1; wdata = 16'hFFFD; cycle(); wr0 = 0;
    wr1 = 1; wdata = 16'hFFFB; cycle(); wr1 = 0;
    sw_clr = 1; cycle(); sw_clr = 0;
    while (cnt_o !== TOP) cycle();
    #1 chk1("R4", "eoc at FFFF", eoc_o, 1'b1);
    cycle();
    chk16("R6", "first reload from slot0", cnt_o, 16'hFFFD);
    dual = 0; cycle(); dual = 1;
    cycle(); cycle();
    chk16("R6", "pointer forced to slot0", cnt_o, 16'hFFFD);
    repeat (3) cycle();
    chk16("R6", "alternate reload slot1", cnt_o, 16'hFFFB);
    repeat (4) cycle();
    sw_clr = 1; wr0 = 1; wdata = 16'd3;
    #1 chk1("R12", "clear suppresses eoc", eoc_o, 1'b0);
    cycle(); sw_clr = 0; wr0 = 0;
    chk16("R12", "clear beats reload", cnt_o, 16'h0000);

    // R5 single period
    down = 1; dual = 0; cont = 0;
    #1 chk1("R4", "eoc at 0000 down", eoc_o, 1'b1);
    cycle();
    chk16("R5", "reload value", cnt_o, 16'd3);
    repeat (3) cycle();
    chk16("R5", "stopped", cnt_o, 16'd3);
    chk1("R5", "no eoc while stopped", eoc_o, 1'b0);
    sw_clr = 1; cycle(); sw_clr = 0;
    cycle();
    chk16("R5", "runs after clear", cnt_o, 16'hFFFE);

    // R3 free-running wrap through zero
    down = 0; sw_clr = 1; cycle(); sw_clr = 0;
    down = 1; s0cap = 1; cont = 1;
    #1 chk1("R3", "no eoc in free run", eoc_o, 1'b0);
    cycle();
    chk16("R3", "wrap to FFFF", cnt_o, TOP);

    // constrained random phase
    for (int i = 0; i < 20000; i++) begin
      if (i % 150 == 0) begin
        down = 1'($urandom); cont = 1'($urandom); dual = 1'($urandom);
        s0cap = 1'($urandom); mon_dis = 1'($urandom); clr_cap = 1'($urandom);
        clr_cmp = 1'($urandom); psc_ld = P'($urandom % 3);
      end
      cap    = ($urandom % 8) == 0;
      sw_clr = ($urandom % 40) == 0;
      wr0    = ($urandom % 30) == 0;
      wr1    = ($urandom % 30) == 0;
      wrm    = ($urandom % 30) == 0;
      case ($urandom % 4)
        0: wdata = W'($urandom % 8);
        1: wdata = TOP - W'($urandom % 8);
        2: wdata = W'($urandom);
        default: wdata = cnt_o + W'($urandom % 4);
      endcase
      cycle();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule